// File: doc/BRIEF.md
# MII receive status classifier

This block sits on the MAC side of a 4-bit media-independent receive interface and runs on the receive clock. Every cycle it looks at the receive nibble, the data-valid and error strobes and the synchronized carrier and collision lines. It places the cycle in exactly one class: idle, in-frame data, in-frame error, partner low-power indication, false carrier, or PHY absent. It also reports collisions when the port runs in half duplex.

In parallel, a framer searches each valid burst for the start-of-frame delimiter. It tolerates a preamble of any length, including a badly truncated one. After the delimiter it packs nibbles into bytes, low nibble first, and marks the first byte. When data-valid drops it gives a one-cycle end strobe that carries the frame's error status. Three saturating counters record false-carrier events, errored frames and entries into low-power indication.

Top module: `mii_rx_classifier`

## Requirements
- R1: `rx_class` is registered one clock after the inputs it describes, with codes 0 idle, 1 in-frame data, 2 in-frame error, 3 low-power indication, 4 false carrier, 5 PHY absent. Priority runs: data-valid high (code 2 if `rx_er` else code 1), then the error-strobe codes, then PHY absent, then idle.
- R2: With `rx_dv` low and `rx_er` high, nibble 4'h1 gives class 3 and raises `lpi_flag`, and nibble 4'hE gives class 4 and raises `fcar_flag`. Each flag stays high for as long as the code is held. Any other nibble gives idle and counts nothing.
- R3: A cycle with `rx_dv` and `rx_er` both high gives class 2. `frame_err` then rises and stays high for every remaining cycle of that frame.
- R4: After the delimiter, each pair of nibbles forms one byte `{second, first}` on `byte_data`, with a one-cycle `byte_valid` in the cycle after the second nibble. `byte_sof` is high only with the first byte of a frame.
- R5: The delimiter is one or more 4'h5 nibbles followed by 4'hD, all with `rx_dv` high. A burst that starts with any other nibble, or breaks the 4'h5 run with anything but 4'hD, yields no bytes and no end strobe.
- R6: `crs_async` and `col_async` pass through two synchronizer stages. In half duplex, a synchronized `col_async` high with `crs_async` low sets `phy_absent`, three clocks after the inputs change.
- R7: `collision` is high only in half duplex, with both synchronized `col_async` and `crs_async` high. In full duplex it is forced low, as is `phy_absent`.
- R8: In the cycle after `rx_dv` is first sampled low at the end of a frame that found its delimiter, `eof_strobe` pulses for one clock. `eof_err` is high if the frame saw `rx_er` or ended on an unpaired nibble.
- R9: `cnt_fcar` adds one per false-carrier episode, `cnt_lpi` one per low-power entry, and `cnt_ferr` one per frame containing `rx_er`, however many error cycles it has. Each counter stops at all ones.
- R10: `rst_rx_n` low clears all outputs and counters at once without a clock. Its release takes effect through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock |
| rst_rx_n | input | 1 | Asynchronous active-low reset |
| half_duplex | input | 1 | Half-duplex mode select |
| rxd | input | 4 | Receive nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| crs_async | input | 1 | Carrier sense, asynchronous |
| col_async | input | 1 | Collision line, asynchronous, weakly pulled up |
| rx_class | output | 3 | Class code for the previous cycle |
| lpi_flag | output | 1 | Partner low-power indication held |
| fcar_flag | output | 1 | False carrier held |
| phy_absent | output | 1 | PHY missing or disconnected |
| collision | output | 1 | Collision in half duplex |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | Byte strobe |
| byte_sof | output | 1 | First byte of frame |
| eof_strobe | output | 1 | End-of-frame pulse |
| eof_err | output | 1 | Error status with end pulse |
| frame_err | output | 1 | Error latched in current frame |
| cnt_fcar | output | CNT_W | False-carrier episode count |
| cnt_ferr | output | CNT_W | Errored frame count |
| cnt_lpi | output | CNT_W | Low-power entry count |

## Verification
Frames are sent with a full preamble, with a single preamble nibble and with no 4'h5 before the delimiter. These cases separate delimiter hunting from any fixed preamble-length assumption. Errored frames carry several error cycles, to show that a frame is counted once and not once per cycle. An unpaired trailing nibble checks that an alignment fault reaches the end status. With data-valid low, the error-strobe codes 4'h1, 4'hE and an undefined code show that only the two defined codes classify and count. Collision and carrier combinations in both duplex modes, with a priority clash against a low-power code, separate PHY absence from a collision. Repeated low-power entries on a narrow counter reach saturation.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  localparam int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [2:0] {
    CLS_IDLE   = 3'd0,
    CLS_DATA   = 3'd1,
    CLS_FERR   = 3'd2,
    CLS_LPI    = 3'd3,
    CLS_FCAR   = 3'd4,
    CLS_ABSENT = 3'd5
  } rx_class_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_PRE,
    FR_DATA,
    FR_DROP
  } framer_st_e;

  localparam logic [NIB_W-1:0] NIB_PRE    = 4'h5;
  localparam logic [NIB_W-1:0] NIB_SFD_HI = 4'hD;
  localparam logic [NIB_W-1:0] CODE_LPI   = 4'h1;
  localparam logic [NIB_W-1:0] CODE_FCAR  = 4'hE;

endpackage

// File: rtl/mii_cdc_sync.sv
module mii_cdc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mii_sat_counter.sv
module mii_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/mii_rx_sorter.sv
module mii_rx_sorter
  import mii_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] rxd,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic             half_duplex,
  input  logic             col_s,
  input  logic             crs_s,
  output logic [2:0]       rx_class,
  output logic             lpi_flag,
  output logic             fcar_flag,
  output logic             phy_absent,
  output logic             collision,
  output logic             lpi_enter,
  output logic             fcar_enter
);

  rx_class_e cls_q;
  rx_class_e cls_d;
  logic      absent_q;
  logic      absent_d;
  logic      col_q;
  logic      col_d;

  always_comb begin
    absent_d = half_duplex && col_s && !crs_s;
    col_d    = half_duplex && col_s && crs_s;
    if (rx_dv) begin
      cls_d = rx_er ? CLS_FERR : CLS_DATA;
    end else if (rx_er && (rxd == CODE_LPI)) begin
      cls_d = CLS_LPI;
    end else if (rx_er && (rxd == CODE_FCAR)) begin
      cls_d = CLS_FCAR;
    end else if (absent_d) begin
      cls_d = CLS_ABSENT;
    end else begin
      cls_d = CLS_IDLE;
    end
    lpi_enter  = (cls_d == CLS_LPI)  && (cls_q != CLS_LPI);
    fcar_enter = (cls_d == CLS_FCAR) && (cls_q != CLS_FCAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q    <= CLS_IDLE;
      absent_q <= 1'b0;
      col_q    <= 1'b0;
    end else begin
      cls_q    <= cls_d;
      absent_q <= absent_d;
      col_q    <= col_d;
    end
  end

  assign rx_class   = cls_q;
  assign lpi_flag   = (cls_q == CLS_LPI);
  assign fcar_flag  = (cls_q == CLS_FCAR);
  assign phy_absent = absent_q;
  assign collision  = col_q;

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_dv,
  input  logic              rx_er,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              byte_sof,
  output logic              eof_strobe,
  output logic              eof_err,
  output logic              frame_err,
  output logic              ferr_first
);

  framer_st_e        st_q, st_d;
  logic              half_q, half_d;
  logic [NIB_W-1:0]  low_q, low_d;
  logic              first_q, first_d;
  logic              err_q, err_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              bv_q, bv_d;
  logic              sof_q, sof_d;
  logic              eof_q, eof_d;
  logic              eoferr_q, eoferr_d;

  always_comb begin
    st_d       = st_q;
    half_d     = half_q;
    low_d      = low_q;
    first_d    = first_q;
    byte_d     = byte_q;
    bv_d       = 1'b0;
    sof_d      = 1'b0;
    eof_d      = 1'b0;
    eoferr_d   = 1'b0;
    err_d      = rx_dv ? (err_q || rx_er) : 1'b0;
    ferr_first = rx_dv && rx_er && !err_q;
    if (!rx_dv) begin
      if (st_q == FR_DATA) begin
        eof_d    = 1'b1;
        eoferr_d = err_q || half_q;
      end
      st_d   = FR_IDLE;
      half_d = 1'b0;
    end else begin
      case (st_q)
        FR_IDLE: begin
          st_d = (rxd == NIB_PRE) ? FR_PRE : FR_DROP;
        end
        FR_PRE: begin
          if (rxd == NIB_SFD_HI) begin
            st_d    = FR_DATA;
            half_d  = 1'b0;
            first_d = 1'b1;
          end else if (rxd != NIB_PRE) begin
            st_d = FR_DROP;
          end
        end
        FR_DATA: begin
          if (!half_q) begin
            low_d  = rxd;
            half_d = 1'b1;
          end else begin
            byte_d  = {rxd, low_q};
            bv_d    = 1'b1;
            sof_d   = first_q;
            first_d = 1'b0;
            half_d  = 1'b0;
          end
        end
        default: begin
          st_d = FR_DROP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FR_IDLE;
      half_q   <= 1'b0;
      low_q    <= '0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
      byte_q   <= '0;
      bv_q     <= 1'b0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      eoferr_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      half_q   <= half_d;
      low_q    <= low_d;
      first_q  <= first_d;
      err_q    <= err_d;
      byte_q   <= byte_d;
      bv_q     <= bv_d;
      sof_q    <= sof_d;
      eof_q    <= eof_d;
      eoferr_q <= eoferr_d;
    end
  end

  assign byte_data  = byte_q;
  assign byte_valid = bv_q;
  assign byte_sof   = sof_q;
  assign eof_strobe = eof_q;
  assign eof_err    = eoferr_q;
  assign frame_err  = err_q;

endmodule

// File: rtl/mii_rx_classifier.sv
module mii_rx_classifier
  import mii_rx_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_rx,
  input  logic              rst_rx_n,
  input  logic              half_duplex,
  input  logic [3:0]        rxd,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic              crs_async,
  input  logic              col_async,
  output logic [2:0]        rx_class,
  output logic              lpi_flag,
  output logic              fcar_flag,
  output logic              phy_absent,
  output logic              collision,
  output logic [7:0]        byte_data,
  output logic              byte_valid,
  output logic              byte_sof,
  output logic              eof_strobe,
  output logic              eof_err,
  output logic              frame_err,
  output logic [CNT_W-1:0]  cnt_fcar,
  output logic [CNT_W-1:0]  cnt_ferr,
  output logic [CNT_W-1:0]  cnt_lpi
);

  localparam int N_CNT = 3;
  localparam int RST_STG = 2;

  logic [RST_STG-1:0] rst_pipe_q;
  logic               rst_n;

  always_ff @(posedge clk_rx or negedge rst_rx_n) begin
    if (!rst_rx_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STG-2:0], 1'b1};
    end
  end

  assign rst_n = rst_pipe_q[RST_STG-1];

  logic [1:0] line_sync;

  mii_cdc_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk_rx),
    .rst_n   (rst_n),
    .d_async ({col_async, crs_async}),
    .d_sync  (line_sync)
  );

  logic lpi_enter;
  logic fcar_enter;
  logic ferr_first;

  mii_rx_sorter u_sorter (
    .clk         (clk_rx),
    .rst_n       (rst_n),
    .rxd         (rxd),
    .rx_dv       (rx_dv),
    .rx_er       (rx_er),
    .half_duplex (half_duplex),
    .col_s       (line_sync[1]),
    .crs_s       (line_sync[0]),
    .rx_class    (rx_class),
    .lpi_flag    (lpi_flag),
    .fcar_flag   (fcar_flag),
    .phy_absent  (phy_absent),
    .collision   (collision),
    .lpi_enter   (lpi_enter),
    .fcar_enter  (fcar_enter)
  );

  mii_rx_framer u_framer (
    .clk        (clk_rx),
    .rst_n      (rst_n),
    .rxd        (rxd),
    .rx_dv      (rx_dv),
    .rx_er      (rx_er),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_sof   (byte_sof),
    .eof_strobe (eof_strobe),
    .eof_err    (eof_err),
    .frame_err  (frame_err),
    .ferr_first (ferr_first)
  );

  logic [N_CNT-1:0]            inc_vec;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_vec;

  assign inc_vec = {lpi_enter, ferr_first, fcar_enter};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    mii_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk_rx),
      .rst_n (rst_n),
      .inc   (inc_vec[g]),
      .count (cnt_vec[g])
    );
  end

  assign cnt_fcar = cnt_vec[0];
  assign cnt_ferr = cnt_vec[1];
  assign cnt_lpi  = cnt_vec[2];

endmodule

// File: rtl/mii_rx_classifier_chk.sv
module mii_rx_classifier_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_rx,
  input logic             rst_rx_n,
  input logic             half_duplex,
  input logic [3:0]       rxd,
  input logic             rx_dv,
  input logic             rx_er,
  input logic [2:0]       rx_class,
  input logic             lpi_flag,
  input logic             phy_absent,
  input logic             collision,
  input logic             byte_valid,
  input logic             eof_strobe,
  input logic             frame_err,
  input logic [CNT_W-1:0] cnt_fcar,
  input logic [CNT_W-1:0] cnt_ferr,
  input logic [CNT_W-1:0] cnt_lpi
);

  AST_CLASS_LEGAL: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    rx_class <= 3'd5); // R1

  AST_LPI_NEEDS_CODE: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    lpi_flag |-> $past(rx_er && !rx_dv && (rxd == 4'h1))); // R2

  AST_FERR_HELD: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    (frame_err && rx_dv) |=> frame_err); // R3

  AST_BYTE_EOF_APART: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    !(byte_valid && eof_strobe)); // R4

  AST_ABSENT_NOT_COL: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    !(phy_absent && collision)); // R6

  AST_FULLDUP_QUIET: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    (collision || phy_absent) |-> $past(half_duplex)); // R7

  AST_EOF_AFTER_DV_LOW: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    eof_strobe |-> !$past(rx_dv)); // R8

  AST_CNT_MONOTONIC: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    (cnt_fcar >= $past(cnt_fcar)) && (cnt_ferr >= $past(cnt_ferr))
    && (cnt_lpi >= $past(cnt_lpi))); // R9

endmodule

bind mii_rx_classifier mii_rx_classifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_rx      (clk_rx),
  .rst_rx_n    (rst_rx_n),
  .half_duplex (half_duplex),
  .rxd         (rxd),
  .rx_dv       (rx_dv),
  .rx_er       (rx_er),
  .rx_class    (rx_class),
  .lpi_flag    (lpi_flag),
  .phy_absent  (phy_absent),
  .collision   (collision),
  .byte_valid  (byte_valid),
  .eof_strobe  (eof_strobe),
  .frame_err   (frame_err),
  .cnt_fcar    (cnt_fcar),
  .cnt_ferr    (cnt_ferr),
  .cnt_lpi     (cnt_lpi)
);

// File: tb/test_mii_rx_classifier.sv
module test_mii_rx_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          half_duplex = 1'b0;
  logic [3:0]    rxd = 4'h0;
  logic          rx_dv = 1'b0;
  logic          rx_er = 1'b0;
  logic          crs_async = 1'b0;
  logic          col_async = 1'b0;
  logic [2:0]    rx_class;
  logic          lpi_flag, fcar_flag, phy_absent, collision;
  logic [7:0]    byte_data;
  logic          byte_valid, byte_sof, eof_strobe, eof_err, frame_err;
  logic [CW-1:0] cnt_fcar, cnt_ferr, cnt_lpi;

  int n_chk = 0;
  int n_fail = 0;
  int ex_fcar = 0;
  int ex_ferr = 0;
  int ex_lpi = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mii_rx_classifier #(.CNT_W(CW)) i_mii_rx_classifier (
    .clk_rx(clk), .rst_rx_n(rst_n), .half_duplex(half_duplex),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .crs_async(crs_async), .col_async(col_async),
    .rx_class(rx_class), .lpi_flag(lpi_flag), .fcar_flag(fcar_flag),
    .phy_absent(phy_absent), .collision(collision),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .eof_strobe(eof_strobe), .eof_err(eof_err), .frame_err(frame_err),
    .cnt_fcar(cnt_fcar), .cnt_ferr(cnt_ferr), .cnt_lpi(cnt_lpi)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic drive(input logic [3:0] d, input logic dv, input logic er);
    rxd = d; rx_dv = dv; rx_er = er;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_counters(input string req);
    check(req, "cnt_fcar", int'(cnt_fcar), sat(ex_fcar));
    check(req, "cnt_ferr", int'(cnt_ferr), sat(ex_ferr));
    check(req, "cnt_lpi", int'(cnt_lpi), sat(ex_lpi));
  endtask

  // R4 R5 R8 R3: send one burst and check bytes, markers and end status
  task automatic run_frame(input string req, input int npre, input int nbytes,
                           input int err_a, input int err_b, input bit odd);
    logic [3:0] nibs[$];
    logic [7:0] exp_b[$];
    int got = 0;
    int bad_byte = 0;
    int bad_sof = 0;
    int bad_cls = 0;
    int bad_ferr = 0;
    bit seen_err = 0;
    bit framed = (npre > 0);
    for (int i = 0; i < npre; i++) nibs.push_back(4'h5);
    nibs.push_back(4'hD);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = 8'(8'h3C + i * 8'h2B);
      exp_b.push_back(b);
      nibs.push_back(b[3:0]);
      nibs.push_back(b[7:4]);
    end
    if (odd) nibs.push_back(4'h9);
    for (int j = 0; j < nibs.size(); j++) begin
      bit er = (j == err_a) || (j == err_b);
      drive(nibs[j], 1'b1, er);
      if (er) seen_err = 1;
      if (rx_class != (er ? 3'd2 : 3'd1)) bad_cls++;
      if (frame_err != seen_err) bad_ferr++;
      if (byte_valid) begin
        if (got >= exp_b.size() || byte_data != exp_b[got]) bad_byte++;
        if (byte_sof != (got == 0)) bad_sof++;
        got++;
      end else if (byte_sof) begin
        bad_sof++;
      end
    end
    if (seen_err) ex_ferr++;
    check({req, " R1"}, "class mismatches in frame", bad_cls, 0);
    check({req, " R3"}, "frame_err mismatches", bad_ferr, 0);
    check({req, " R4"}, "byte count", got, framed ? nbytes : 0);
    check({req, " R4"}, "byte value mismatches", bad_byte, 0);
    check({req, " R4"}, "sof mismatches", bad_sof, 0);
    drive(4'h0, 1'b0, 1'b0);
    check({req, " R8"}, "eof_strobe", int'(eof_strobe), int'(framed));
    check({req, " R8"}, "eof_err", int'(eof_err), int'(framed && (seen_err || odd)));
    check({req, " R3"}, "frame_err cleared", int'(frame_err), 0);
    drive(4'h0, 1'b0, 1'b0);
    check({req, " R8"}, "eof_strobe one cycle", int'(eof_strobe), 0);
    check_counters({req, " R9"});
  endtask

  // R2: out-of-frame error-strobe code held for n cycles
  task automatic run_code(input string req, input logic [3:0] code, input int n,
                          input int exp_cls);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      drive(code, 1'b0, 1'b1);
      if (rx_class != 3'(exp_cls)) bad++;
      if (lpi_flag != (exp_cls == 3)) bad++;
      if (fcar_flag != (exp_cls == 4)) bad++;
    end
    if (exp_cls == 3) ex_lpi++;
    if (exp_cls == 4) ex_fcar++;
    check(req, "class and flags while held", bad, 0);
    drive(4'h0, 1'b0, 1'b0);
    check(req, "flags drop after code", int'(lpi_flag | fcar_flag), 0);
    check_counters({req, " R9"});
  endtask

  // R6 R7: set line levels, allow the sync and register stages to settle
  task automatic run_lines(input string req, input bit hd, input bit col,
                           input bit crs, input int exp_abs, input int exp_col);
    half_duplex = hd; col_async = col; crs_async = crs;
    repeat (4) drive(4'h0, 1'b0, 1'b0);
    check(req, "phy_absent", int'(phy_absent), exp_abs);
    check(req, "collision", int'(collision), exp_col);
    check({req, " R1"}, "class", int'(rx_class), exp_abs ? 5 : 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R10", "class in reset", int'(rx_class), 0);
    check("R10", "byte_valid in reset", int'(byte_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "eof after release", int'(eof_strobe), 0);
    check_counters("R10");
  endtask

  task automatic test_latency();
    @(negedge clk);
    rxd = 4'h1; rx_dv = 1'b0; rx_er = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "class one edge after input", int'(rx_class), 3);
    @(negedge clk);
    ex_lpi++;
    drive(4'h0, 1'b0, 1'b0);
  endtask

  task automatic test_async_reset();
    rst_n = 1'b0;
    #1;
    check("R10", "counters clear without clock",
          int'(cnt_fcar) + int'(cnt_ferr) + int'(cnt_lpi), 0);
    ex_fcar = 0; ex_ferr = 0; ex_lpi = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_saturation();
    for (int i = 0; i < CMAX + 5; i++) begin
      drive(4'h1, 1'b0, 1'b1);
      drive(4'h0, 1'b0, 1'b0);
      ex_lpi++;
    end
    check("R9", "cnt_lpi saturated", int'(cnt_lpi), CMAX);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    test_reset();
    test_latency();
    run_frame("R5 full preamble", 15, 5, -1, -1, 1'b0);
    run_frame("R5 short preamble", 1, 3, -1, -1, 1'b0);
    run_frame("R5 missing preamble", 0, 3, -1, -1, 1'b0);
    run_frame("R3 errored frame", 4, 4, 8, 10, 1'b0);
    run_frame("R8 odd nibble", 3, 2, -1, -1, 1'b1);
    run_code("R2 low-power code", 4'h1, 3, 3);
    run_code("R2 low-power again", 4'h1, 1, 3);
    run_code("R2 false carrier", 4'hE, 2, 4);
    run_code("R2 undefined code", 4'h3, 2, 0);
    run_lines("R6 absent", 1'b1, 1'b1, 1'b0, 1, 0);
    drive(4'h1, 1'b0, 1'b1);
    ex_lpi++;
    check("R1", "low-power code beats absent", int'(rx_class), 3);
    run_lines("R7 collision", 1'b1, 1'b1, 1'b1, 0, 1);
    run_lines("R7 full duplex col", 1'b0, 1'b1, 1'b1, 0, 0);
    run_lines("R7 full duplex absent", 1'b0, 1'b1, 1'b0, 0, 0);
    run_lines("R6 lines quiet", 1'b1, 1'b0, 1'b0, 0, 0);
    check_counters("R9 totals");
    test_async_reset();
    test_saturation();
    report();
    $finish;
  end

endmodule